// File: doc/BRIEF.md
# Asynchronous SRAM Bus Sequencer

This block connects an internal requester to an external asynchronous SRAM-style bus. The requester presents a read or a write with a byte address, an access size and a byte-order flag. The block then runs fixed two-cycle bus accesses with no wait states. Each access has a start strobe, an active-low chip select, a read strobe, one write enable per byte lane, an address output and a data bus with a separate output enable. The device width is 16 or 32 bits and is chosen by parameter.

A request can be a single access or a 32-byte line transfer. A line transfer issues back-to-back beats at the device width. The first beat is the word that holds the requested address. The later beats step upward and wrap within the aligned 32-byte block. Chip select stays low for the whole line. Read data comes back one beat at a time on a response port, and a done pulse marks the end of every transfer.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While and right after reset, `mem_bs_n`, `mem_cs_n` and `mem_rd_n` are high, every `mem_we_n` bit is high, `mem_dq_oe` is low, and `req_ready` is high.
- R2: A request accepted on a clock edge starts T1 on the next cycle and T2 on the cycle after. `mem_bs_n` is low in T1 only. `mem_cs_n` is low in both T1 and T2 and returns high after T2 when nothing follows.
- R3: A request that is accepted on the edge that ends a transfer's final T2 starts its T1 at once. `mem_cs_n` does not go high between the two accesses.
- R4: A read holds `mem_rd_n` low through T1 and T2 with all write enables high. `mem_addr` is the request address with its lowest log2(BUS_W/8) bits cleared. On the cycle after T2, `rsp_valid` is high and `rsp_rdata` carries the full `mem_dq_in` word sampled at the end of T2, whatever `req_size` was.
- R5: A single write with `req_size` 0 (byte), 1 (halfword) or 2 (word) pulls low only the write enables of the bytes written, and drives `mem_dq_oe` high. The value is taken from the low bytes of `req_wdata`. Little-endian (`req_big_end`=0): the byte at lane offset k goes on lane k, and value byte 0 goes to the lowest address. Big-endian: offset k goes on lane BUS_W/8-1-k, and the most significant value byte goes to the lowest address.
- R6: A line transfer (`req_line`=1) runs 32/(BUS_W/8) beats back to back. Beat 0 addresses the aligned requested word. Each later beat adds BUS_W/8 modulo 32 within the same 32-byte block. `mem_bs_n` pulses low in every beat's T1, and `mem_cs_n` stays low from the first T1 to the last T2.
- R7: A line read produces one `rsp_valid` beat per bus beat, in bus order. `rsp_done` is high together with the last beat's response.
- R8: A line write drives all write enables low on every beat. Byte i of the line (address offset i) sits at bits [8i+7:8i] of `req_line_wdata`, and it is placed on lanes by the same endian rule as R5.
- R9: `rsp_done` is high for exactly the one cycle after the final T2 of every transfer, read or write.
- R10: `req_ready` is low in T1 and in every T2 except the final T2 of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = 32-byte line transfer |
| req_size | input | 2 | Single write size: 0 byte, 1 half, 2 word |
| req_big_end | input | 1 | 1 = big-endian lane mapping |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Single write value, right-aligned |
| req_line_wdata | input | 8*LINE_BYTES | Line write data, byte i at bits 8i |
| rsp_valid | output | 1 | Read beat data valid |
| rsp_rdata | output | BUS_W | Read beat data, full device width |
| rsp_done | output | 1 | Transfer complete pulse |
| mem_bs_n | output | 1 | Bus-cycle start strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | BUS_W/8 | Per-lane write enables, active low |
| mem_addr | output | ADDR_W | Byte address, aligned to device width |
| mem_dq_out | output | BUS_W | Write data to the pins |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | BUS_W | Read data from the pins |

## Verification
The bench starts a line read in the middle of a block. A sequencer that counted from the block base, or carried the address into the next block, would give a wrong beat address. The bench sends byte and halfword writes at non-zero offsets in both byte orders. Mirrored lane numbering or reversed value bytes would show up as wrong write enables or wrong data. It also issues two reads back to back and tracks chip-select gaps. A controller that waited an idle cycle before taking the next request would be counted with a negation period, and a stretched or missing done pulse is caught on the cycle it occurs.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2
  } bus_phase_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int BUS_W = 32,
  localparam int BYTES = BUS_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  input  logic             big_end,
  input  logic [31:0]      wdata,
  output logic [BYTES-1:0] mask,
  output logic [BUS_W-1:0] data
);
  always_comb begin
    mask = '0;
    data = '0;
    for (int l = 0; l < BYTES; l++) begin
      int k;
      int j;
      int nb;
      int src;
      nb = 1 << size;
      k  = big_end ? (BYTES - 1 - l) : l;
      j  = k - int'(off);
      src = big_end ? (nb - 1 - j) : j;
      if (j >= 0 && j < nb && src >= 0 && src < 4) begin
        mask[l] = 1'b1;
        data[8*l +: 8] = wdata[8*src +: 8];
      end
    end
  end
endmodule

// File: rtl/sram_line_slice.sv
module sram_line_slice #(
  parameter int BUS_W = 32,
  parameter int LINE_BYTES = 32,
  localparam int BYTES = BUS_W / 8,
  localparam int LOFF_W = $clog2(LINE_BYTES)
) (
  input  logic [8*LINE_BYTES-1:0] line,
  input  logic [LOFF_W-1:0]       off,
  input  logic                    big_end,
  output logic [BUS_W-1:0]        data
);
  always_comb begin
    data = '0;
    for (int l = 0; l < BYTES; l++) begin
      int k;
      int idx;
      k   = big_end ? (BYTES - 1 - l) : l;
      idx = (int'(off) + k) % LINE_BYTES;
      data[8*l +: 8] = line[8*idx +: 8];
    end
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int BUS_W = 32,
  parameter int LINE_BYTES = 32,
  localparam int BYTES = BUS_W / 8,
  localparam int LOFF_W = $clog2(LINE_BYTES),
  localparam int BEATS = LINE_BYTES / BYTES,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic                    req_line,
  input  logic [1:0]              req_size,
  input  logic                    req_big_end,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  input  logic [8*LINE_BYTES-1:0] req_line_wdata,
  output logic                    rsp_valid,
  output logic [BUS_W-1:0]        rsp_rdata,
  output logic                    rsp_done,
  output logic                    mem_bs_n,
  output logic                    mem_cs_n,
  output logic                    mem_rd_n,
  output logic [BYTES-1:0]        mem_we_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [BUS_W-1:0]        mem_dq_out,
  output logic                    mem_dq_oe,
  input  logic [BUS_W-1:0]        mem_dq_in
);
  bus_phase_t                phase;
  logic [BEAT_W-1:0]         beat_cnt;
  logic [ADDR_W-LOFF_W-1:0]  blk_q;
  logic [LOFF_W-1:0]         off_q;
  logic                      is_wr_q, is_line_q, be_q;
  logic [8*LINE_BYTES-1:0]   line_buf_q;

  logic                      last_beat, accept;
  logic [LOFF_W-1:0]         start_off, nxt_off, slice_off;
  logic [8*LINE_BYTES-1:0]   slice_src;
  logic                      slice_be;
  logic [BUS_W-1:0]          slice_data, map_data, acc_data;
  logic [BYTES-1:0]          map_mask, acc_mask;

  assign last_beat = !is_line_q || (beat_cnt == BEAT_W'(BEATS - 1));
  assign req_ready = (phase == PH_IDLE) || (phase == PH_T2 && last_beat);
  assign accept    = req_valid && req_ready;
  assign start_off = req_addr[LOFF_W-1:0] & ~LOFF_W'(BYTES - 1);
  assign nxt_off   = off_q + LOFF_W'(BYTES);
  assign slice_src = accept ? req_line_wdata : line_buf_q;
  assign slice_off = accept ? start_off : nxt_off;
  assign slice_be  = accept ? req_big_end : be_q;

  sram_line_slice #(.BUS_W(BUS_W), .LINE_BYTES(LINE_BYTES)) u_slice (
    .line(slice_src), .off(slice_off), .big_end(slice_be), .data(slice_data)
  );

  sram_lane_map #(.BUS_W(BUS_W)) u_map (
    .off(req_addr[$clog2(BYTES)-1:0]), .size(req_size), .big_end(req_big_end),
    .wdata(req_wdata), .mask(map_mask), .data(map_data)
  );

  always_comb begin
    acc_mask = '0;
    if (req_write) acc_mask = req_line ? '1 : map_mask;
    acc_data = req_line ? slice_data : map_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      beat_cnt   <= '0;
      blk_q      <= '0;
      off_q      <= '0;
      is_wr_q    <= 1'b0;
      is_line_q  <= 1'b0;
      be_q       <= 1'b0;
      line_buf_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_done   <= 1'b0;
      mem_bs_n   <= 1'b1;
      mem_cs_n   <= 1'b1;
      mem_rd_n   <= 1'b1;
      mem_we_n   <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_done  <= 1'b0;
      case (phase)
        PH_T1: begin
          phase    <= PH_T2;
          mem_bs_n <= 1'b1;
        end
        PH_T2: begin
          if (!is_wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_in;
          end
          if (!last_beat) begin
            beat_cnt   <= beat_cnt + 1'b1;
            off_q      <= nxt_off;
            mem_bs_n   <= 1'b0;
            mem_addr   <= {blk_q, nxt_off};
            mem_dq_out <= slice_data;
            phase      <= PH_T1;
          end else begin
            rsp_done  <= 1'b1;
            phase     <= PH_IDLE;
            mem_cs_n  <= 1'b1;
            mem_rd_n  <= 1'b1;
            mem_we_n  <= '1;
            mem_dq_oe <= 1'b0;
          end
        end
        default: ;
      endcase
      if (accept) begin
        phase      <= PH_T1;
        blk_q      <= req_addr[ADDR_W-1:LOFF_W];
        off_q      <= start_off;
        beat_cnt   <= '0;
        is_wr_q    <= req_write;
        is_line_q  <= req_line;
        be_q       <= req_big_end;
        line_buf_q <= req_line_wdata;
        mem_bs_n   <= 1'b0;
        mem_cs_n   <= 1'b0;
        mem_rd_n   <= req_write;
        mem_we_n   <= ~acc_mask;
        mem_addr   <= {req_addr[ADDR_W-1:LOFF_W], start_off};
        mem_dq_out <= acc_data;
        mem_dq_oe  <= req_write;
      end
    end
  end

  // R2
  bs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_bs_n |=> mem_bs_n);
  // R2
  cs_span_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_bs_n |=> !mem_cs_n);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> (&mem_we_n));
  // R4
  rsp_src_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!mem_rd_n && mem_bs_n && !mem_cs_n));
  // R6
  wrap_block_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_T1 && beat_cnt != '0) |->
      (mem_addr[ADDR_W-1:LOFF_W] == $past(mem_addr[ADDR_W-1:LOFF_W]) &&
       mem_addr[LOFF_W-1:0] == $past(mem_addr[LOFF_W-1:0]) + LOFF_W'(BYTES)));
  // R9
  done_after_t2_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(mem_bs_n && !mem_cs_n));
  // R10
  ready_t1_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_bs_n |-> !req_ready);
endmodule

// File: tb/tb_sram_bus_ctrl.sv
module tb_sram_bus_ctrl;
  localparam int ADDR_W = 26;
  localparam int BUS_W = 32;
  localparam int LINE_BYTES = 32;
  localparam int BYTES = BUS_W / 8;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic [BYTES-1:0]  mask;
    logic [BUS_W-1:0]  data;
    logic              last;
  } beat_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_line = 1'b0, req_big_end = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [8*LINE_BYTES-1:0] req_line_wdata = '0;
  logic req_ready, rsp_valid, rsp_done;
  logic [BUS_W-1:0] rsp_rdata;
  logic mem_bs_n, mem_cs_n, mem_rd_n, mem_dq_oe;
  logic [BYTES-1:0] mem_we_n;
  logic [ADDR_W-1:0] mem_addr;
  logic [BUS_W-1:0] mem_dq_out, mem_dq_in;

  int checks = 0;
  int fails = 0;
  int gap_cnt = 0;
  beat_t beat_q[$];
  logic [BUS_W-1:0] rsp_q[$];

  always #4 clk = ~clk;

  function automatic logic [BUS_W-1:0] mdl(input logic [ADDR_W-1:0] a);
    logic [31:0] t;
    t = {~a[15:0], a[15:0]};
    return t[BUS_W-1:0];
  endfunction

  assign mem_dq_in = mdl(mem_addr);

  sram_bus_ctrl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .LINE_BYTES(LINE_BYTES)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .req_size(req_size),
    .req_big_end(req_big_end), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_line_wdata(req_line_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .mem_bs_n(mem_bs_n), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: pushes expected bus beats and read responses, then hands over the request
  task automatic issue(input logic wr, input logic line, input logic [1:0] sz,
                       input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                       input logic [8*LINE_BYTES-1:0] ld, input logic be);
    int n;
    int start;
    n = line ? LINE_BYTES / BYTES : 1;
    start = int'(a[4:0]) & ~(BYTES - 1);
    for (int b = 0; b < n; b++) begin
      beat_t e;
      int off;
      off = (start + b * BYTES) % LINE_BYTES;
      e.addr = {a[ADDR_W-1:5], 5'(off)};
      e.rd = !wr;
      e.mask = '0;
      e.data = '0;
      e.last = (b == n - 1);
      if (wr && line) begin
        e.mask = '1;
        for (int l = 0; l < BYTES; l++)
          e.data[8*l +: 8] = ld[8*(off + (be ? BYTES - 1 - l : l)) +: 8];
      end else if (wr) begin
        int nb;
        nb = 1 << sz;
        for (int j = 0; j < nb; j++) begin
          int pos;
          int lane;
          pos = int'(a) % BYTES + j;
          lane = be ? BYTES - 1 - pos : pos;
          e.mask[lane] = 1'b1;
          e.data[8*lane +: 8] = be ? wd[8*(nb-1-j) +: 8] : wd[8*j +: 8];
        end
      end
      beat_q.push_back(e);
      if (!wr) rsp_q.push_back(mdl(e.addr));
    end
    req_write = wr; req_line = line; req_size = sz; req_addr = a;
    req_wdata = wd; req_line_wdata = ld; req_big_end = be; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (beat_q.size() != 0 || rsp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor
  logic  in_t2 = 1'b0, was_t2 = 1'b0, done_due = 1'b0, rsp_due = 1'b0;
  beat_t cur;
  always @(negedge clk) begin
    if (!rst) begin
      if (done_due || rsp_done)
        chk(rsp_done == done_due, "R9 done pulse", 64'(rsp_done), 64'(done_due));
      if (rsp_due || rsp_valid) begin
        chk(rsp_valid == rsp_due, "R7 response valid", 64'(rsp_valid), 64'(rsp_due));
        if (rsp_valid && rsp_q.size() != 0) begin
          logic [BUS_W-1:0] ex;
          ex = rsp_q.pop_front();
          chk(rsp_rdata == ex, "R4 read data full width", 64'(rsp_rdata), 64'(ex));
        end
      end
      done_due = 1'b0;
      rsp_due = 1'b0;
      if (in_t2) begin
        chk(mem_bs_n && !mem_cs_n, "R2 T2 strobes", {mem_bs_n, mem_cs_n}, 2'b10);
        chk(mem_rd_n == !cur.rd && mem_we_n == ~cur.mask, "R2 T2 held strobes",
            64'({mem_rd_n, mem_we_n}), 64'({!cur.rd, ~cur.mask}));
        chk(req_ready == cur.last, "R10 ready in T2", 64'(req_ready), 64'(cur.last));
        in_t2 = 1'b0;
        was_t2 = 1'b1;
        done_due = cur.last;
        rsp_due = cur.rd;
      end else if (!mem_bs_n) begin
        if (beat_q.size() == 0) begin
          chk(1'b0, "R2 unexpected bus cycle", 64'(mem_addr), 64'(0));
        end else begin
          cur = beat_q.pop_front();
          chk(mem_addr == cur.addr, "R6 beat address", 64'(mem_addr), 64'(cur.addr));
          chk(!mem_cs_n && mem_rd_n == !cur.rd, "R4 T1 cs/rd",
              64'({mem_cs_n, mem_rd_n}), 64'({1'b0, !cur.rd}));
          chk(mem_we_n == ~cur.mask, "R5 write enables", 64'(mem_we_n), 64'(~cur.mask));
          if (!cur.rd)
            chk(mem_dq_out == cur.data && mem_dq_oe, "R8 write data",
                64'(mem_dq_out), 64'(cur.data));
          chk(!req_ready, "R10 ready in T1", 64'(req_ready), 64'(0));
        end
        in_t2 = 1'b1;
        was_t2 = 1'b0;
      end else begin
        if (was_t2 && mem_cs_n) gap_cnt++;
        was_t2 = 1'b0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int g0;
    logic [8*LINE_BYTES-1:0] ld;
    for (int i = 0; i < LINE_BYTES; i++) ld[8*i +: 8] = 8'(8'h40 + i);
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk(mem_bs_n && mem_cs_n && mem_rd_n && (&mem_we_n) && !mem_dq_oe && req_ready,
        "R1 reset state", 64'({mem_bs_n, mem_cs_n, mem_rd_n, mem_dq_oe, req_ready}), 64'b11101);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && req_ready, "R1 after reset", 64'({mem_cs_n, req_ready}), 64'b11);

    // R4 single reads, aligned and unaligned with byte size
    issue(1'b0, 1'b0, 2'd2, 26'h0123456, 32'h0, ld, 1'b0);
    wait_idle();
    issue(1'b0, 1'b0, 2'd0, 26'h0000ACF, 32'h0, ld, 1'b1);
    wait_idle();
    // R5 writes in both byte orders
    issue(1'b1, 1'b0, 2'd0, 26'h0000101, 32'h000000A7, ld, 1'b0);
    wait_idle();
    issue(1'b1, 1'b0, 2'd0, 26'h0000101, 32'h000000A7, ld, 1'b1);
    wait_idle();
    issue(1'b1, 1'b0, 2'd1, 26'h0000202, 32'h0000BEEF, ld, 1'b0);
    wait_idle();
    issue(1'b1, 1'b0, 2'd1, 26'h0000202, 32'h0000BEEF, ld, 1'b1);
    wait_idle();
    issue(1'b1, 1'b0, 2'd2, 26'h0000300, 32'h11223344, ld, 1'b1);
    wait_idle();
    // R3 back-to-back reads keep chip select low
    g0 = gap_cnt;
    issue(1'b0, 1'b0, 2'd2, 26'h0000400, 32'h0, ld, 1'b0);
    issue(1'b0, 1'b0, 2'd2, 26'h0000408, 32'h0, ld, 1'b0);
    wait_idle();
    chk(gap_cnt - g0 == 1, "R3 no cs gap between accesses", 64'(gap_cnt - g0), 64'd1);
    // R6 R7 line read from mid-block, wraps
    g0 = gap_cnt;
    issue(1'b0, 1'b1, 2'd2, 26'h1ABCD14, 32'h0, ld, 1'b0);
    wait_idle();
    chk(gap_cnt - g0 == 1, "R6 cs held through line", 64'(gap_cnt - g0), 64'd1);
    // R8 line writes in both orders
    issue(1'b1, 1'b1, 2'd2, 26'h0002208, 32'h0, ld, 1'b1);
    wait_idle();
    issue(1'b1, 1'b1, 2'd2, 26'h000331C, 32'h0, ld, 1'b0);
    wait_idle();
    chk(beat_q.size() == 0 && rsp_q.size() == 0, "R9 all transfers completed",
        64'(beat_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule